// File: doc/BRIEF.md
# Serial Command Line Receiver

This block listens on one asynchronous serial input and collects the characters it receives into a line held in on-chip storage. It is driven by a sampling enable that pulses eight times per bit period. It decodes frames of eight data bits with no parity and one stop bit. Control codes are thrown away and printable codes are appended to the line.

A carriage return ends the line. It raises a ready flag that stays set until the host asserts clear. While the flag is set, the line is frozen. The host reads the stored characters by index through a combinational read port. A length output gives the number of characters held, and the entry just past the last character always reads as zero. A sticky overflow flag reports characters that arrived when the line was already full. A one-cycle pulse reports a frame whose stop bit was low.

Top module: `cmdline_rx`

## Requirements
- R1: After reset, `cmd_len` is 0, `cmd_ready`, `overflow` and `frame_err` are 0, and index 0 reads 0x00.
- R2: `rxd` passes through a two-flop synchronizer. Frames are decoded at 8 samples per bit, LSB first. A start bit is accepted only if the line is still low at the fourth sample. A low pulse of two samples stores nothing.
- R3: Each received code of 32 or above is appended to the line. Index 0 holds the oldest character, and `cmd_len` counts the characters stored.
- R4: Codes 0 to 31, including backspace (8), are discarded and leave `cmd_len` unchanged. Code 32 is stored.
- R5: Code 13 sets `cmd_ready` and is not stored.
- R6: The entry at index `cmd_len` always reads 0x00.
- R7: While `cmd_ready` is 1, received characters (including 13) change neither the length nor the contents.
- R8: The line holds at most DEPTH (32) characters. A printable character that arrives when the line is full is dropped and sets `overflow`, which stays set until clear.
- R9: If the stop bit samples low, `frame_err` pulses for one cycle and the character is not stored.
- R10: `clear` empties the line and resets `cmd_ready` and `overflow` on the next cycle. A character that completes while `clear` is high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sampling enable, 8 pulses per bit |
| rxd | input | 1 | Asynchronous serial input, idle high |
| clear | input | 1 | Empty the line and re-arm |
| rd_idx | input | 6 | Read index |
| rd_data | output | 8 | Character at `rd_idx` (0x00 beyond the line) |
| cmd_ready | output | 1 | Terminator seen; line frozen |
| cmd_len | output | 6 | Number of stored characters |
| overflow | output | 1 | Sticky: a character was dropped because the line was full |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |

## Verification
A character can complete in the same cycle that the host asserts clear. Clear must win and the character must vanish.

The bench provokes this by holding clear high across the whole stop bit of a frame. The character's completion therefore falls inside the clear window whatever its exact cycle. The bench then checks that the length, the ready flag and the overflow flag read zero, and that the next character lands at index 0.

Overflow and the terminator are also exercised back to back. The flags are compared against a behavioural queue model on every settled clock.

// File: rtl/cmdline_pkg.sv
package cmdline_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;
endpackage

// File: rtl/cmdline_sync.sv
module cmdline_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.sh = {r_q.sh[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '1;
        else        r_q <= r_d;
    end

    assign dout = r_q.sh[STAGES-1];
endmodule

// File: rtl/cmdline_frame.sv
module cmdline_frame
    import cmdline_pkg::*;
#(
    parameter int OVS   = 8,
    parameter int DBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx,
    output logic             byte_vld,
    output logic [DBITS-1:0] byte_data,
    output logic             frame_err
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DBITS);
    localparam logic [CW-1:0] LAST_TICK = CW'(OVS - 1);
    localparam logic [CW-1:0] MID_TICK  = CW'(OVS / 2 - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(DBITS - 1);

    typedef struct packed {
        rx_state_e        state;
        logic [CW-1:0]    cnt;
        logic [BW-1:0]    bitn;
        logic [DBITS-1:0] shreg;
        logic             vld;
        logic             ferr;
    } frm_t;

    frm_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        r_d.ferr = 1'b0;
        if (tick) begin
            unique case (r_q.state)
                RX_IDLE: begin
                    if (!rx) begin
                        r_d.state = RX_START;
                        r_d.cnt   = CW'(1);
                    end
                end
                RX_START: begin
                    if (r_q.cnt == MID_TICK) begin
                        r_d.cnt  = '0;
                        r_d.bitn = '0;
                        r_d.state = rx ? RX_IDLE : RX_DATA;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (r_q.cnt == LAST_TICK) begin
                        r_d.cnt   = '0;
                        r_d.shreg = {rx, r_q.shreg[DBITS-1:1]};
                        if (r_q.bitn == LAST_BIT) r_d.state = RX_STOP;
                        else                      r_d.bitn  = r_q.bitn + 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (r_q.cnt == LAST_TICK) begin
                        r_d.cnt = '0;
                        if (rx) begin
                            r_d.vld   = 1'b1;
                            r_d.state = RX_IDLE;
                        end else begin
                            r_d.ferr  = 1'b1;
                            r_d.state = RX_BREAK;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_BREAK: begin
                    if (rx) r_d.state = RX_IDLE;
                end
                default: r_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: RX_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign byte_vld  = r_q.vld;
    assign byte_data = r_q.shreg;
    assign frame_err = r_q.ferr;
endmodule

// File: rtl/cmdline_buf.sv
module cmdline_buf #(
    parameter int         DEPTH = 32,
    parameter logic [7:0] TERM  = 8'd13,
    parameter logic [7:0] MINP  = 8'd32,
    localparam int        LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          in_vld,
    input  logic [7:0]    in_data,
    input  logic [LW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic [LW-1:0] len,
    output logic          ready,
    output logic          ovf
);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    typedef struct packed {
        logic [DEPTH:0][7:0] mem;
        logic [LW-1:0]       len;
        logic                ready;
        logic                ovf;
    } line_t;

    line_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.mem   = '0;
            r_d.len   = '0;
            r_d.ready = 1'b0;
            r_d.ovf   = 1'b0;
        end else if (in_vld && !r_q.ready) begin
            if (in_data == TERM) begin
                r_d.ready = 1'b1;
            end else if (in_data >= MINP) begin
                if (r_q.len == FULL) begin
                    r_d.ovf = 1'b1;
                end else begin
                    r_d.mem[r_q.len]        = in_data;
                    r_d.mem[r_q.len + 1'b1] = 8'h00;
                    r_d.len                 = r_q.len + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data = (rd_idx <= FULL) ? r_q.mem[rd_idx] : 8'h00;
    assign len     = r_q.len;
    assign ready   = r_q.ready;
    assign ovf     = r_q.ovf;
endmodule

// File: rtl/cmdline_rx.sv
module cmdline_rx #(
    parameter int         OVS         = 8,
    parameter int         DEPTH       = 32,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] TERM_CODE   = 8'd13,
    parameter logic [7:0] MIN_PRINT   = 8'd32,
    localparam int        LW          = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          clear,
    input  logic [LW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic          cmd_ready,
    output logic [LW-1:0] cmd_len,
    output logic          overflow,
    output logic          frame_err
);
    logic       rx_sync;
    logic       byte_vld;
    logic [7:0] byte_data;

    cmdline_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_sync)
    );

    cmdline_frame #(.OVS(OVS), .DBITS(8)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rx       (rx_sync),
        .byte_vld (byte_vld),
        .byte_data(byte_data),
        .frame_err(frame_err)
    );

    cmdline_buf #(.DEPTH(DEPTH), .TERM(TERM_CODE), .MINP(MIN_PRINT)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .in_vld (byte_vld),
        .in_data(byte_data),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .len    (cmd_len),
        .ready  (cmd_ready),
        .ovf    (overflow)
    );
endmodule

// File: rtl/cmdline_rx_chk.sv
module cmdline_rx_chk #(
    parameter int         DEPTH = 32,
    parameter int         LW    = 6,
    parameter logic [7:0] TERM  = 8'd13,
    parameter logic [7:0] MINP  = 8'd32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic          byte_vld,
    input logic [7:0]    byte_data,
    input logic [LW-1:0] rd_idx,
    input logic [7:0]    rd_data,
    input logic          cmd_ready,
    input logic [LW-1:0] cmd_len,
    input logic          overflow,
    input logic          frame_err
);
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_len <= LW'(DEPTH)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !clear |=> overflow); // R8
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready && !clear |=> cmd_ready); // R7
    AST_READY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready && !clear |=> $stable(cmd_len)); // R7
    AST_CTRL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld && (byte_data < MINP) && !clear |=> $stable(cmd_len)); // R4
    AST_TERM_READY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld && (byte_data == TERM) && !clear |=> cmd_ready); // R5
    AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == cmd_len) |-> (rd_data == 8'h00)); // R6
    AST_FERR_NOSTORE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err && !clear |=> $stable(cmd_len)); // R9
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cmd_len == '0) && !cmd_ready && !overflow); // R10
endmodule

bind cmdline_rx cmdline_rx_chk #(
    .DEPTH(DEPTH),
    .LW   (LW),
    .TERM (TERM_CODE),
    .MINP (MIN_PRINT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .byte_vld (byte_vld),
    .byte_data(byte_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .cmd_ready(cmd_ready),
    .cmd_len  (cmd_len),
    .overflow (overflow),
    .frame_err(frame_err)
);

// File: tb/test_cmdline_rx.sv
module test_cmdline_rx;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick;
    logic          rxd = 1'b1;
    logic          clear = 1'b0;
    logic [LW-1:0] rd_idx = '0;
    logic [7:0]    rd_data;
    logic          cmd_ready;
    logic [LW-1:0] cmd_len;
    logic          overflow;
    logic          frame_err;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int ferr_seen = 0;
    int ferr_exp = 0;
    bit settled = 0;
    bit done = 0;

    logic [7:0] q[$];
    bit m_ready = 0;
    bit m_ovf = 0;

    logic [1:0] tdiv;

    always #4 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) tdiv <= '0;
        else        tdiv <= tdiv + 2'd1;
    end
    assign tick = (tdiv == 2'd3);

    cmdline_rx i_cmdline_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rxd      (rxd),
        .clear    (clear),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .cmd_ready(cmd_ready),
        .cmd_len  (cmd_len),
        .overflow (overflow),
        .frame_err(frame_err)
    );

    task automatic check(string req, int act, int exp, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) if (rst_n && frame_err) ferr_seen++;

    // reference model compared on every settled clock
    always @(negedge clk) begin
        if (settled && !done) begin
            check("R3", int'(cmd_len), q.size(), "length vs model");
            check("R5", int'(cmd_ready), int'(m_ready), "ready vs model");
            check("R8", int'(overflow), int'(m_ovf), "overflow vs model");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic model_byte(logic [7:0] c);
        if (m_ready) return;
        if (c == 8'd13) m_ready = 1;
        else if (c >= 8'd32) begin
            if (q.size() == 32) m_ovf = 1;
            else q.push_back(c);
        end
    endtask

    task automatic model_clear();
        q.delete();
        m_ready = 0;
        m_ovf = 0;
    endtask

    task automatic send(logic [7:0] c, bit stop_val = 1'b1, bit clr_in_stop = 1'b0);
        settled = 0;
        @(negedge clk) rxd = 1'b0;
        repeat (32) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = c[i];
            repeat (32) @(negedge clk);
        end
        rxd = stop_val;
        if (clr_in_stop) clear = 1'b1;
        repeat (32) @(negedge clk);
        clear = 1'b0;
        rxd = 1'b1;
        repeat (16) @(negedge clk);
        if (clr_in_stop) model_clear();
        else if (!stop_val) ferr_exp++;
        else model_byte(c);
        settled = 1;
    endtask

    task automatic do_clear();
        settled = 0;
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
        model_clear();
        settled = 1;
    endtask

    task automatic check_buf(string req);
        for (int i = 0; i <= q.size(); i++) begin
            @(negedge clk) rd_idx = LW'(i);
            #1;
            check(req, int'(rd_data), (i < q.size()) ? int'(q[i]) : 0, $sformatf("rd_data[%0d]", i));
        end
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", int'(cmd_len), 0, "len after reset");
        check("R1", int'(cmd_ready), 0, "ready after reset");
        check("R1", int'(overflow), 0, "overflow after reset");
        check("R1", int'(frame_err), 0, "frame_err after reset");
        check("R1", int'(rd_data), 0, "index 0 after reset");
        do_clear();

        // R3: printable characters in order
        send(8'h48);
        send(8'h69);
        check_buf("R3");
        // R4: control codes dropped, code 32 stored
        send(8'h08);
        send(8'h00);
        send(8'h1F);
        check("R4", int'(cmd_len), 2, "len after control codes");
        send(8'h20);
        send(8'hFF);
        check_buf("R4");

        // R2: short low glitch is not a start bit
        settled = 0;
        @(negedge clk) rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
        settled = 1;
        check("R2", int'(cmd_len), 4, "len after glitch");

        // R9: low stop bit
        send(8'h5A, 1'b0);
        check("R9", ferr_seen, ferr_exp, "frame_err pulses");
        check("R9", int'(cmd_len), 4, "len after framing error");

        // R5/R6: terminator
        send(8'h0D);
        check("R5", int'(cmd_ready), 1, "ready after CR");
        check_buf("R6");

        // R7: ignored while ready
        send(8'h51);
        send(8'h0D);
        check("R7", int'(cmd_len), 4, "len while ready");
        check_buf("R7");

        // R10: clear
        do_clear();
        check("R10", int'(cmd_len), 0, "len after clear");
        check("R10", int'(cmd_ready), 0, "ready after clear");

        // R8: fill and overflow
        for (int i = 0; i < 32; i++) send(8'h61 + 8'(i % 26));
        check("R8", int'(cmd_len), 32, "len when full");
        check("R8", int'(overflow), 0, "no overflow when exactly full");
        send(8'h7A);
        send(8'h79);
        check("R8", int'(overflow), 1, "overflow set");
        check_buf("R8");
        send(8'h0D);
        check("R8", int'(overflow), 1, "overflow sticky");

        // R10: clear coinciding with character completion
        send(8'h78, 1'b1, 1'b1);
        check("R10", int'(cmd_len), 0, "len after clear during stop");
        check("R10", int'(overflow), 0, "overflow after clear during stop");
        check("R10", int'(cmd_ready), 0, "ready after clear during stop");
        send(8'h6B);
        check_buf("R10");
        check("R9", ferr_seen, ferr_exp, "final frame_err count");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule